// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control unit of a single-bus processor datapath. A small step counter marks where the machine is within the current instruction; the current step and the opcode from the instruction register are decoded into gate enables (which source drives the shared bus), strobe enables (which register captures the bus), an ALU function code, register-field selects and memory request lines. Every instruction begins with the same three-step fetch. After that come the steps of add, add-immediate, load, store, conditional branch and shift right.

The counter does not simply count up. It freezes while a step waits on memory and no completion has arrived. It returns to step 0 when a step signals the end of the instruction. It reloads step 6 to repeat the shift step while the shift count is nonzero. A synchronous reset overrides all of these. Some outputs depend on datapath flags: the shift-count-zero flag and the branch condition flag. All outputs are combinational decodes of the registered step, the opcode and the flags. The block has no data path of its own, so there is no streaming handshake. Every pin is a plain control level.

Top module: `ctl_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `step` is 0 after that edge, whatever else is asserted, including a stalled memory wait.
- R2: Steps 0 to 2 are identical for every opcode. Step 0 asserts gate_pc, strobe_ma, strobe_c, mem_rd, with alu_fn=2 (add four). Step 1 asserts gate_c, strobe_pc, mem_wait. Step 2 asserts gate_md, strobe_ir. ALU codes are 0 pass bus, 1 add, 2 add four, 3 shift right one.
- R3: While mem_wait is high and mem_done is low, `step` keeps its value at the next edge. Once mem_done is high, the sequence goes on.
- R4: A step asserting seq_end (and not held by R3) is followed by step 0.
- R5: Opcode 12 (add): step 3 sel_rb, gate_reg, strobe_a. Step 4 sel_rc, gate_reg, alu_fn=1, strobe_c. Step 5 gate_c, sel_ra, strobe_reg, seq_end.
- R6: Opcode 13 (add immediate) equals add except step 4, which uses gate_imm_long instead of sel_rc with gate_reg.
- R7: Opcode 3 (store): step 3 sel_rb, gate_base, strobe_a. Step 4 gate_imm_long, alu_fn=1, strobe_c. Step 5 gate_c, strobe_ma. Step 6 sel_ra, gate_reg, strobe_md, mem_wr. Step 7 mem_wait, seq_end, and it holds at step 7 until mem_done.
- R8: Opcode 1 (load): steps 3 to 5 as store. Step 6 mem_rd, mem_wait, strobe_md. Step 7 gate_md, sel_ra, strobe_reg, seq_end.
- R9: Opcode 8 (branch): step 3 sel_rc, gate_reg, strobe_cond. Step 4 sel_rb, gate_reg, seq_end, with strobe_pc equal to cond_flag.
- R10: Opcode 26 (shift right): step 3 gate_imm_short, cnt_load. Step 4 sel_rc, gate_reg, cnt_load only when cnt_zero is high, otherwise nothing. Step 5 sel_rb, gate_reg, alu_fn=0, strobe_c.
- R11: Shift right step 6 with cnt_zero low asserts gate_c, alu_fn=3, strobe_c, cnt_decr, and step 6 repeats. With cnt_zero high it asserts nothing and step 7 follows. Step 7 asserts gate_c, sel_ra, strobe_reg, seq_end.
- R12: Any other opcode asserts only seq_end in step 3.
- R13: At most one gate output and at most one register-field select are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to step 0 |
| opcode | input | OP_W | Opcode field of the instruction register |
| mem_done | input | 1 | Memory has completed the pending access |
| cnt_zero | input | 1 | Shift counter is zero |
| cond_flag | input | 1 | Latched branch condition |
| step | output | STEP_W | Current control step |
| gate_pc | output | 1 | Program counter drives bus |
| gate_reg | output | 1 | Selected general register drives bus |
| gate_base | output | 1 | Selected register drives bus, zero for register 0 |
| gate_c | output | 1 | ALU result register drives bus |
| gate_md | output | 1 | Memory data register drives bus |
| gate_imm_long | output | 1 | Sign-extended long immediate drives bus |
| gate_imm_short | output | 1 | Sign-extended short immediate drives bus |
| strobe_ma | output | 1 | Memory address register captures bus |
| strobe_c | output | 1 | ALU result register captures ALU output |
| strobe_pc | output | 1 | Program counter captures bus |
| strobe_ir | output | 1 | Instruction register captures bus |
| strobe_a | output | 1 | ALU operand register captures bus |
| strobe_reg | output | 1 | Selected general register captures bus |
| strobe_md | output | 1 | Memory data register captures |
| strobe_cond | output | 1 | Condition flip-flop captures condition logic |
| alu_fn | output | 2 | ALU function code |
| sel_ra | output | 1 | Select destination register field |
| sel_rb | output | 1 | Select first source register field |
| sel_rc | output | 1 | Select second source register field |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wait | output | 1 | Step waits for mem_done |
| seq_end | output | 1 | Last step of the instruction |
| cnt_load | output | 1 | Shift counter loads from bus |
| cnt_decr | output | 1 | Shift counter decrements |

## Verification
Two pairs of counter actions can fall in one cycle. A wait hold and an end both arrive in step 7 of a store. The bench delays mem_done by two cycles there, and the step must stay at 7 until completion and only then return to 0. Reset also lands on a stalled wait and in the middle of a store, and reset must win. The opcode sweep runs each instruction with zero and two cycles of memory delay, with both flag polarities, and with three passes through the shift loop. Each cycle's outputs and step are compared with a table worked out from the requirements.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int OPC_LD   = 1;
  localparam int OPC_ST   = 3;
  localparam int OPC_BR   = 8;
  localparam int OPC_ADD  = 12;
  localparam int OPC_ADDI = 13;
  localparam int OPC_SHR  = 26;

  localparam int LOOP_STEP = 6;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_INC4 = 2'd2,
    ALU_SHR  = 2'd3
  } alu_fn_e;

  typedef enum logic [2:0] {
    K_ADD, K_ADDI, K_LD, K_ST, K_BR, K_SHR, K_BAD
  } ins_kind_e;

  typedef struct packed {
    logic    gate_pc;
    logic    gate_reg;
    logic    gate_base;
    logic    gate_c;
    logic    gate_md;
    logic    gate_imm_long;
    logic    gate_imm_short;
    logic    strobe_ma;
    logic    strobe_c;
    logic    strobe_pc;
    logic    strobe_ir;
    logic    strobe_a;
    logic    strobe_reg;
    logic    strobe_md;
    logic    strobe_cond;
    alu_fn_e alu;
    logic    sel_ra;
    logic    sel_rb;
    logic    sel_rc;
    logic    mem_rd;
    logic    mem_wr;
    logic    mem_wait;
    logic    seq_end;
    logic    cnt_load;
    logic    cnt_decr;
    logic    loop_back;
  } ctl_word_t;

endpackage

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
  import ctl_seq_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic [OP_W-1:0] opcode,
  output ins_kind_e       kind
);

  always_comb begin
    case (int'(opcode))
      OPC_ADD:  kind = K_ADD;
      OPC_ADDI: kind = K_ADDI;
      OPC_LD:   kind = K_LD;
      OPC_ST:   kind = K_ST;
      OPC_BR:   kind = K_BR;
      OPC_SHR:  kind = K_SHR;
      default:  kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/ctl_word_gen.sv
module ctl_word_gen
  import ctl_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  ins_kind_e         kind,
  input  logic              cnt_zero,
  input  logic              cond_flag,
  output ctl_word_t         cw
);

  always_comb begin
    cw     = '0;
    cw.alu = ALU_PASS;
    case (int'(step))
      0: begin
        cw.gate_pc   = 1'b1;
        cw.strobe_ma = 1'b1;
        cw.strobe_c  = 1'b1;
        cw.alu       = ALU_INC4;
        cw.mem_rd    = 1'b1;
      end
      1: begin
        cw.gate_c    = 1'b1;
        cw.strobe_pc = 1'b1;
        cw.mem_wait  = 1'b1;
      end
      2: begin
        cw.gate_md   = 1'b1;
        cw.strobe_ir = 1'b1;
      end
      3: begin
        case (kind)
          K_ADD, K_ADDI: begin
            cw.sel_rb   = 1'b1;
            cw.gate_reg = 1'b1;
            cw.strobe_a = 1'b1;
          end
          K_LD, K_ST: begin
            cw.sel_rb    = 1'b1;
            cw.gate_base = 1'b1;
            cw.strobe_a  = 1'b1;
          end
          K_BR: begin
            cw.sel_rc      = 1'b1;
            cw.gate_reg    = 1'b1;
            cw.strobe_cond = 1'b1;
          end
          K_SHR: begin
            cw.gate_imm_short = 1'b1;
            cw.cnt_load       = 1'b1;
          end
          default: cw.seq_end = 1'b1;
        endcase
      end
      4: begin
        case (kind)
          K_ADD: begin
            cw.sel_rc   = 1'b1;
            cw.gate_reg = 1'b1;
            cw.alu      = ALU_ADD;
            cw.strobe_c = 1'b1;
          end
          K_ADDI, K_LD, K_ST: begin
            cw.gate_imm_long = 1'b1;
            cw.alu           = ALU_ADD;
            cw.strobe_c      = 1'b1;
          end
          K_BR: begin
            cw.sel_rb    = 1'b1;
            cw.gate_reg  = 1'b1;
            cw.strobe_pc = cond_flag;
            cw.seq_end   = 1'b1;
          end
          K_SHR: begin
            if (cnt_zero) begin
              cw.sel_rc   = 1'b1;
              cw.gate_reg = 1'b1;
              cw.cnt_load = 1'b1;
            end
          end
          default: ;
        endcase
      end
      5: begin
        case (kind)
          K_ADD, K_ADDI: begin
            cw.gate_c     = 1'b1;
            cw.sel_ra     = 1'b1;
            cw.strobe_reg = 1'b1;
            cw.seq_end    = 1'b1;
          end
          K_LD, K_ST: begin
            cw.gate_c    = 1'b1;
            cw.strobe_ma = 1'b1;
          end
          K_SHR: begin
            cw.sel_rb   = 1'b1;
            cw.gate_reg = 1'b1;
            cw.strobe_c = 1'b1;
          end
          default: ;
        endcase
      end
      6: begin
        case (kind)
          K_LD: begin
            cw.mem_rd    = 1'b1;
            cw.mem_wait  = 1'b1;
            cw.strobe_md = 1'b1;
          end
          K_ST: begin
            cw.sel_ra    = 1'b1;
            cw.gate_reg  = 1'b1;
            cw.strobe_md = 1'b1;
            cw.mem_wr    = 1'b1;
          end
          K_SHR: begin
            if (!cnt_zero) begin
              cw.gate_c    = 1'b1;
              cw.alu       = ALU_SHR;
              cw.strobe_c  = 1'b1;
              cw.cnt_decr  = 1'b1;
              cw.loop_back = 1'b1;
            end
          end
          default: ;
        endcase
      end
      7: begin
        case (kind)
          K_LD: begin
            cw.gate_md    = 1'b1;
            cw.sel_ra     = 1'b1;
            cw.strobe_reg = 1'b1;
            cw.seq_end    = 1'b1;
          end
          K_ST: begin
            cw.mem_wait = 1'b1;
            cw.seq_end  = 1'b1;
          end
          K_SHR: begin
            cw.gate_c     = 1'b1;
            cw.sel_ra     = 1'b1;
            cw.strobe_reg = 1'b1;
            cw.seq_end    = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctl_step_ctr.sv
module ctl_step_ctr #(
  parameter int STEP_W = 3,
  parameter int LOOP   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              restart,
  input  logic              jump,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] JUMP_VAL = STEP_W'(LOOP);
  localparam logic [STEP_W-1:0] ONE      = STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          step <= '0;
    else if (hold)    step <= step;
    else if (restart) step <= '0;
    else if (jump)    step <= JUMP_VAL;
    else              step <= step + ONE;
  end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_seq_pkg::*;
#(
  parameter int OP_W   = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              mem_done,
  input  logic              cnt_zero,
  input  logic              cond_flag,
  output logic [STEP_W-1:0] step,
  output logic              gate_pc,
  output logic              gate_reg,
  output logic              gate_base,
  output logic              gate_c,
  output logic              gate_md,
  output logic              gate_imm_long,
  output logic              gate_imm_short,
  output logic              strobe_ma,
  output logic              strobe_c,
  output logic              strobe_pc,
  output logic              strobe_ir,
  output logic              strobe_a,
  output logic              strobe_reg,
  output logic              strobe_md,
  output logic              strobe_cond,
  output logic [1:0]        alu_fn,
  output logic              sel_ra,
  output logic              sel_rb,
  output logic              sel_rc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wait,
  output logic              seq_end,
  output logic              cnt_load,
  output logic              cnt_decr
);

  ins_kind_e kind;
  ctl_word_t cw;

  ctl_op_decode #(.OP_W(OP_W)) u_dec (
    .opcode (opcode),
    .kind   (kind)
  );

  ctl_word_gen #(.STEP_W(STEP_W)) u_gen (
    .step      (step),
    .kind      (kind),
    .cnt_zero  (cnt_zero),
    .cond_flag (cond_flag),
    .cw        (cw)
  );

  ctl_step_ctr #(.STEP_W(STEP_W), .LOOP(LOOP_STEP)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .hold    (cw.mem_wait & ~mem_done),
    .restart (cw.seq_end),
    .jump    (cw.loop_back),
    .step    (step)
  );

  assign gate_pc        = cw.gate_pc;
  assign gate_reg       = cw.gate_reg;
  assign gate_base      = cw.gate_base;
  assign gate_c         = cw.gate_c;
  assign gate_md        = cw.gate_md;
  assign gate_imm_long  = cw.gate_imm_long;
  assign gate_imm_short = cw.gate_imm_short;
  assign strobe_ma      = cw.strobe_ma;
  assign strobe_c       = cw.strobe_c;
  assign strobe_pc      = cw.strobe_pc;
  assign strobe_ir      = cw.strobe_ir;
  assign strobe_a       = cw.strobe_a;
  assign strobe_reg     = cw.strobe_reg;
  assign strobe_md      = cw.strobe_md;
  assign strobe_cond    = cw.strobe_cond;
  assign alu_fn         = cw.alu;
  assign sel_ra         = cw.sel_ra;
  assign sel_rb         = cw.sel_rb;
  assign sel_rc         = cw.sel_rc;
  assign mem_rd         = cw.mem_rd;
  assign mem_wr         = cw.mem_wr;
  assign mem_wait       = cw.mem_wait;
  assign seq_end        = cw.seq_end;
  assign cnt_load       = cw.cnt_load;
  assign cnt_decr       = cw.cnt_decr;

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic              mem_wait,
  input logic              mem_done,
  input logic              seq_end,
  input logic              cnt_decr,
  input logic              gate_pc,
  input logic              gate_reg,
  input logic              gate_base,
  input logic              gate_c,
  input logic              gate_md,
  input logic              gate_imm_long,
  input logic              gate_imm_short,
  input logic              sel_ra,
  input logic              sel_rb,
  input logic              sel_rc,
  input logic              strobe_pc,
  input logic              strobe_ma,
  input logic              mem_rd,
  input logic              cond_flag
);

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> step == '0);

  p_fetch_start_r2: assert property (@(posedge clk) disable iff (rst)
    step == '0 |-> (gate_pc && strobe_ma && mem_rd));

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_wait && !mem_done) |=> $stable(step));

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_wait && !seq_end && !cnt_decr) |=> step == STEP_W'($past(step) + 1'b1));

  p_end_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_end && !(mem_wait && !mem_done)) |=> step == '0);

  p_branch_cond_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe_pc && !gate_c) |-> cond_flag);

  p_loop_back_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_decr |=> step == STEP_W'(6));

  p_gate_onehot_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_pc, gate_reg, gate_base, gate_c, gate_md, gate_imm_long, gate_imm_short}));

  p_sel_onehot_r13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_ra, sel_rb, sel_rc}));

endmodule

bind ctl_sequencer ctl_sequencer_chk #(.STEP_W(STEP_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .step           (step),
  .mem_wait       (mem_wait),
  .mem_done       (mem_done),
  .seq_end        (seq_end),
  .cnt_decr       (cnt_decr),
  .gate_pc        (gate_pc),
  .gate_reg       (gate_reg),
  .gate_base      (gate_base),
  .gate_c         (gate_c),
  .gate_md        (gate_md),
  .gate_imm_long  (gate_imm_long),
  .gate_imm_short (gate_imm_short),
  .sel_ra         (sel_ra),
  .sel_rb         (sel_rb),
  .sel_rc         (sel_rc),
  .strobe_pc      (strobe_pc),
  .strobe_ma      (strobe_ma),
  .mem_rd         (mem_rd),
  .cond_flag      (cond_flag)
);

// File: tb/ctl_sequencer_bench.sv
`timescale 1ns/1ps
module ctl_sequencer_bench;

  localparam int OP_W   = 5;
  localparam int STEP_W = 3;

  typedef struct packed {
    logic       g_pc, g_reg, g_base, g_c, g_md, g_il, g_is;
    logic       s_ma, s_c, s_pc, s_ir, s_a, s_reg, s_md, s_cond;
    logic [1:0] alu;
    logic       ra, rb, rc, rd, wr, wt, fin, ld, dec;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [OP_W-1:0]   opcode = '0;
  logic              mem_done = 1'b0;
  logic              cnt_zero = 1'b0;
  logic              cond_flag = 1'b0;
  logic [STEP_W-1:0] step;
  logic gate_pc, gate_reg, gate_base, gate_c, gate_md, gate_imm_long, gate_imm_short;
  logic strobe_ma, strobe_c, strobe_pc, strobe_ir, strobe_a, strobe_reg, strobe_md, strobe_cond;
  logic [1:0] alu_fn;
  logic sel_ra, sel_rb, sel_rc, mem_rd, mem_wr, mem_wait, seq_end, cnt_load, cnt_decr;

  int checks = 0;
  int failures = 0;
  bit done_all = 1'b0;

  always #5 clk = ~clk;

  ctl_sequencer #(.OP_W(OP_W), .STEP_W(STEP_W)) u_ctl_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .mem_done(mem_done),
    .cnt_zero(cnt_zero), .cond_flag(cond_flag), .step(step),
    .gate_pc(gate_pc), .gate_reg(gate_reg), .gate_base(gate_base), .gate_c(gate_c),
    .gate_md(gate_md), .gate_imm_long(gate_imm_long), .gate_imm_short(gate_imm_short),
    .strobe_ma(strobe_ma), .strobe_c(strobe_c), .strobe_pc(strobe_pc), .strobe_ir(strobe_ir),
    .strobe_a(strobe_a), .strobe_reg(strobe_reg), .strobe_md(strobe_md),
    .strobe_cond(strobe_cond), .alu_fn(alu_fn), .sel_ra(sel_ra), .sel_rb(sel_rb),
    .sel_rc(sel_rc), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wait(mem_wait),
    .seq_end(seq_end), .cnt_load(cnt_load), .cnt_decr(cnt_decr)
  );

  exp_t act;
  assign act = '{gate_pc, gate_reg, gate_base, gate_c, gate_md, gate_imm_long, gate_imm_short,
                 strobe_ma, strobe_c, strobe_pc, strobe_ir, strobe_a, strobe_reg, strobe_md,
                 strobe_cond, alu_fn, sel_ra, sel_rb, sel_rc, mem_rd, mem_wr, mem_wait,
                 seq_end, cnt_load, cnt_decr};

  function automatic exp_t expect_word(int op, int st, bit cz, bit cf);
    exp_t e = '0;
    case (st)
      0: begin e.g_pc = 1; e.s_ma = 1; e.s_c = 1; e.alu = 2'd2; e.rd = 1; end
      1: begin e.g_c = 1; e.s_pc = 1; e.wt = 1; end
      2: begin e.g_md = 1; e.s_ir = 1; end
      default: begin
        case (op)
          12, 13: case (st)
            3: begin e.rb = 1; e.g_reg = 1; e.s_a = 1; end
            4: begin
              if (op == 12) begin e.rc = 1; e.g_reg = 1; end
              else e.g_il = 1;
              e.alu = 2'd1; e.s_c = 1;
            end
            5: begin e.g_c = 1; e.ra = 1; e.s_reg = 1; e.fin = 1; end
            default: ;
          endcase
          1, 3: case (st)
            3: begin e.rb = 1; e.g_base = 1; e.s_a = 1; end
            4: begin e.g_il = 1; e.alu = 2'd1; e.s_c = 1; end
            5: begin e.g_c = 1; e.s_ma = 1; end
            6: if (op == 3) begin e.ra = 1; e.g_reg = 1; e.s_md = 1; e.wr = 1; end
               else begin e.rd = 1; e.wt = 1; e.s_md = 1; end
            7: if (op == 3) begin e.wt = 1; e.fin = 1; end
               else begin e.g_md = 1; e.ra = 1; e.s_reg = 1; e.fin = 1; end
            default: ;
          endcase
          8: case (st)
            3: begin e.rc = 1; e.g_reg = 1; e.s_cond = 1; end
            4: begin e.rb = 1; e.g_reg = 1; e.s_pc = cf; e.fin = 1; end
            default: ;
          endcase
          26: case (st)
            3: begin e.g_is = 1; e.ld = 1; end
            4: if (cz) begin e.rc = 1; e.g_reg = 1; e.ld = 1; end
            5: begin e.rb = 1; e.g_reg = 1; e.s_c = 1; e.alu = 2'd0; end
            6: if (!cz) begin e.g_c = 1; e.alu = 2'd3; e.s_c = 1; e.dec = 1; end
            7: begin e.g_c = 1; e.ra = 1; e.s_reg = 1; e.fin = 1; end
            default: ;
          endcase
          default: if (st == 3) e.fin = 1;
        endcase
      end
    endcase
    return e;
  endfunction

  function automatic string tag_of(int op, int st);
    if (st < 3) return "R2";
    case (op)
      12: return "R5";
      13: return "R6";
      3:  return "R7";
      1:  return "R8";
      8:  return "R9";
      26: return (st >= 6) ? "R11" : "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint a, longint e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, a, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(step == '0, "R1", "step after reset", step, 0);
  endtask

  task automatic run_instr(int op, bit cz4, bit cf, int loops, int delay);
    int  st = 0;
    int  wcnt = 0;
    int  left = loops;
    string stag = "R2";
    do_reset();
    for (int cyc = 0; cyc < 40; cyc++) begin
      exp_t e;
      int nxt;
      bit dn;
      if (cyc != 0) @(negedge clk);
      opcode    = OP_W'(op);
      cond_flag = cf;
      cnt_zero  = (st == 4) ? cz4 : (st == 6) ? (left == 0) : 1'b0;
      dn        = (wcnt >= delay);
      mem_done  = dn;
      #1;
      e = expect_word(op, st, cnt_zero, cf);
      check(int'(step) == st, stag, $sformatf("step op=%0d", op), step, st);
      check(act == e, tag_of(op, st), $sformatf("controls op=%0d step=%0d", op, st), act, e);
      check($onehot0({gate_pc, gate_reg, gate_base, gate_c, gate_md, gate_imm_long,
                      gate_imm_short}) && $onehot0({sel_ra, sel_rb, sel_rc}),
            "R13", "gate/select overlap", act, e);
      if (e.wt && !dn) begin
        wcnt++; nxt = st; stag = "R3";
      end else begin
        wcnt = 0;
        if (e.fin) begin nxt = 0; stag = "R4"; end
        else if (e.dec) begin nxt = 6; left--; stag = "R11"; end
        else begin nxt = st + 1; stag = tag_of(op, st + 1); end
      end
      @(posedge clk);
      st = nxt;
      if (nxt == 0) begin
        #1;
        check(step == '0, "R4", $sformatf("return to step 0 op=%0d", op), step, 0);
        break;
      end
    end
  endtask

  initial begin
    #1;
    check(step == '0, "R1", "initial reset state", step, 0);
    for (int op = 0; op < 32; op++)
      for (int sc = 0; sc < 2; sc++)
        for (int dl = 0; dl < 2; dl++)
          run_instr(op, sc[0], sc[0], (sc == 0) ? 3 : 0, dl * 2);

    // R1: reset in the middle of a store, at step 5
    do_reset();
    opcode = OP_W'(3); mem_done = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(int'(step) == 5, "R1", "store reached step 5", step, 5);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(step == '0, "R1", "reset mid store", step, 0);
    @(negedge clk); rst = 1'b0;

    // R1: reset wins over a stalled wait in step 1
    opcode = OP_W'(12); mem_done = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check(int'(step) == 1, "R3", "stalled in step 1", step, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check(step == '0, "R1", "reset over stalled wait", step, 0);
    @(negedge clk); rst = 1'b0;

    done_all = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done_all) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule